// File: doc/BRIEF.md
# Flash page program-verify sequencer

This block writes one 128-byte page into a flash-like array. It first accepts a page start address and checks that address for alignment. It then takes a stream of bytes, filling any bytes the stream did not supply with 0xFF. After that it repeats two steps: it copies the page into the array's write latch and applies one timed program pulse, then it reads the page back in 16-bit words. Each read word is compared with the intended data.

Some bits may read back as 1 where they should be 0. When that happens, the block rebuilds the latch contents so that only those bits are driven to 0 in the next pulse. Every bit that is already correct is written as 1, so no cell is programmed twice.

Three things end the sequence: a clean verify, reaching the retry cap, or a watchdog that stops a program pulse that runs too long. The result is reported with a one-cycle done strobe and status flags.

Top module: `page_prog_seq`

## Requirements
- R1: A start with address bits [7:0] other than 0x00 or 0x80 is rejected. done_o and err_align_o are high in the cycle after the start edge, pass_o is low, and the array sees no latch write and no program pulse.
- R2: In the load phase, byte_ready_o is high. Each byte accepted (byte_valid_i and byte_ready_o at an edge) goes to the next page offset, starting at 0. byte_last_i ends the stream. After 128 bytes have been accepted, byte_ready_o drops without waiting for byte_last_i.
- R3: When fewer than 128 bytes are supplied, every remaining offset is programmed as 0xFF.
- R4: Each pass writes all 128 latch bytes with fl_latch_o, one per cycle, at consecutive ascending addresses from the page base. The program pulse starts only after all 128 latch writes.
- R5: The first N1 program pulses last PULSE_SHORT cycles each. Every later pulse lasts PULSE_LONG cycles.
- R6: Each group of four bytes is read as follows. First a dummy write of 0xFF (fl_dummy_o) is issued at the group address, whose bits [1:0] are 00. Then two word reads follow, at that address and at that address plus 2. In each word, bits [7:0] hold the byte at the even address.
- R7: The next pass's latch byte is the intended byte OR the inverted readback. A bit that already reads 0 is never driven to 0 again.
- R8: When the readback of the whole page equals the intended data, done_o pulses with pass_o high. Both error flags are low.
- R9: If the page still mismatches after N1+N2 passes, done_o pulses with pass_o low. No further pulse is issued.
- R10: A pulse that would run longer than WDT_LIMIT cycles is forced low after WDT_LIMIT cycles. done_o then pulses with err_wdt_o high and pass_o low.
- R11: A start_i while busy_o is high is ignored. The running sequence keeps its page address, and no other page is touched.
- R12: After reset, busy_o, done_o, pass_o, the error flags, byte_ready_o and all array strobes are low. done_o is high for exactly one cycle per sequence, and the status flags hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| addr_i | input | ADDR_W | Page start address |
| byte_valid_i | input | 1 | Input byte valid |
| byte_data_i | input | 8 | Input byte |
| byte_last_i | input | 1 | Marks the final supplied byte |
| byte_ready_o | output | 1 | Block accepts a byte this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| pass_o | output | 1 | Page verified |
| err_align_o | output | 1 | Start address rejected |
| err_wdt_o | output | 1 | Pulse cut short by the watchdog |
| fl_addr_o | output | ADDR_W | Array address |
| fl_wdata_o | output | 8 | Array write data |
| fl_latch_o | output | 1 | Latch-byte write strobe |
| fl_prog_o | output | 1 | Program pulse |
| fl_dummy_o | output | 1 | Dummy write before verify reads |
| fl_rdata_i | input | 16 | Verify word, valid the cycle after fl_read_o |
| fl_read_o | output | 1 | Verify word read strobe |

## Verification
The alignment reject is due at the first falling edge after the start edge, and the bench samples it there. The byte stall after the 128th byte is checked at the falling edge that follows that byte's acceptance. Pulse widths are measured as the number of rising edges on which fl_prog_o is high, and they are compared with the per-pass value expected from the pass index. All other results are read at the falling edge where done_o is seen, and one edge later the bench confirms that done_o has fallen. The behavioural array model checks latch ordering, the dummy-write protocol and double programming at each rising edge, while the design is doing that work.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_PAD, ST_XFER, ST_PULSE,
    ST_VDUM, ST_VRD, ST_VCAP, ST_EVAL
  } st_e;
endpackage

// File: rtl/page_buf.sv
module page_buf #(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ROW_W = IDX_W - 1,
  localparam int HALF  = DEPTH / 2
) (
  input  logic             clk_i,
  input  logic             ld_we_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [7:0]       ld_data_i,
  input  logic             up_we_i,
  input  logic [ROW_W-1:0] up_row_i,
  input  logic [15:0]      up_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rp_byte_o,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic [15:0]      orig_word_o
);
  logic [1:0][7:0] rp_lane, orig_lane;

  // even/odd byte lanes so a verify word updates both halves in one cycle
  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [7:0] orig_q [HALF];
    logic [7:0] rp_q   [HALF];
    always_ff @(posedge clk_i) begin
      if (ld_we_i && ld_idx_i[0] == 1'(l)) begin
        orig_q[ld_idx_i[IDX_W-1:1]] <= ld_data_i;
        rp_q[ld_idx_i[IDX_W-1:1]]   <= ld_data_i;
      end
      if (up_we_i) rp_q[up_row_i] <= up_data_i[8*l +: 8];
    end
    assign rp_lane[l]   = rp_q[rd_idx_i[IDX_W-1:1]];
    assign orig_lane[l] = orig_q[cmp_row_i];
  end

  assign rp_byte_o   = rp_lane[rd_idx_i[0]];
  assign orig_word_o = orig_lane;
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CNT_W     = 4,
  parameter int WDT_LIMIT = 32,
  localparam int WD_W = $clog2(WDT_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             active_o,
  output logic             end_o,
  output logic             trip_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [WD_W-1:0]  wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      end_o    <= 1'b0;
      trip_o   <= 1'b0;
      cnt_q    <= '0;
      wd_q     <= '0;
    end else begin
      end_o  <= 1'b0;
      trip_o <= 1'b0;
      if (go_i) begin
        active_o <= 1'b1;
        cnt_q    <= '0;
        wd_q     <= '0;
      end else if (active_o) begin
        cnt_q <= cnt_q + 1'b1;
        wd_q  <= wd_q + 1'b1;
        if (cnt_q + 1'b1 == width_i) begin
          active_o <= 1'b0;
          end_o    <= 1'b1;
        end else if (wd_q + 1'b1 == WD_W'(WDT_LIMIT)) begin
          active_o <= 1'b0;
          trip_o   <= 1'b1;
        end
      end
    end
  end

  assert_trip_drops_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |-> !active_o);
  assert_wdt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> wd_q < WD_W'(WDT_LIMIT));
  assert_end_xor_trip_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(end_o && trip_o));
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import pps_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE        = 128,
  parameter int N1          = 2,
  parameter int N2          = 3,
  parameter int PULSE_SHORT = 4,
  parameter int PULSE_LONG  = 9,
  parameter int WDT_LIMIT   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  input  logic              byte_last_i,
  output logic              byte_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              err_align_o,
  output logic              err_wdt_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  output logic              fl_latch_o,
  output logic              fl_prog_o,
  output logic              fl_dummy_o,
  input  logic [15:0]       fl_rdata_i,
  output logic              fl_read_o
);
  localparam int IDX_W    = $clog2(PAGE);
  localparam int IW1      = IDX_W + 1;
  localparam int PASS_MAX = N1 + N2;
  localparam int PC_W     = $clog2(PASS_MAX + 1);
  localparam int PW_MAX   = (PULSE_LONG > PULSE_SHORT) ? PULSE_LONG : PULSE_SHORT;
  localparam int CNT_W    = $clog2(PW_MAX + 1);
  localparam logic [IW1-1:0] LAST  = IW1'(PAGE - 1);
  localparam logic [IW1-1:0] LAST2 = IW1'(PAGE - 2);

  st_e                    st_q;
  logic [ADDR_W-IDX_W-1:0] page_q;
  logic [IW1-1:0]         cnt_q;
  logic [PC_W-1:0]        pass_q;
  logic                   bad_q, done_q, ok_q, ealign_q, ewdt_q;

  logic             aligned, ld_we, up_we, mism, go, p_act, p_end, p_trip;
  logic [IDX_W-1:0] ix;
  logic [7:0]       rp_byte, ld_data;
  logic [15:0]      orig_word, rp_word;
  logic [CNT_W-1:0] width;

  assign aligned = (addr_i[IDX_W-1:0] == '0);
  assign ix      = cnt_q[IDX_W-1:0];
  assign ld_we   = (st_q == ST_LOAD && byte_valid_i) || st_q == ST_PAD;
  assign ld_data = (st_q == ST_PAD) ? 8'hFF : byte_data_i;
  assign up_we   = (st_q == ST_VCAP);
  // drive 0 only where intended 0 still reads 1
  assign rp_word = orig_word | ~fl_rdata_i;
  assign mism    = (fl_rdata_i != orig_word);
  assign go      = (st_q == ST_XFER) && (cnt_q == LAST);
  assign width   = (pass_q < PC_W'(N1)) ? CNT_W'(PULSE_SHORT) : CNT_W'(PULSE_LONG);

  page_buf #(.DEPTH(PAGE)) u_buf (
    .clk_i      (clk_i),
    .ld_we_i    (ld_we),
    .ld_idx_i   (ix),
    .ld_data_i  (ld_data),
    .up_we_i    (up_we),
    .up_row_i   (ix[IDX_W-1:1]),
    .up_data_i  (rp_word),
    .rd_idx_i   (ix),
    .rp_byte_o  (rp_byte),
    .cmp_row_i  (ix[IDX_W-1:1]),
    .orig_word_o(orig_word)
  );

  pulse_timer #(.CNT_W(CNT_W), .WDT_LIMIT(WDT_LIMIT)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .width_i (width),
    .active_o(p_act),
    .end_o   (p_end),
    .trip_o  (p_trip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      page_q   <= '0;
      cnt_q    <= '0;
      pass_q   <= '0;
      bad_q    <= 1'b0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      ealign_q <= 1'b0;
      ewdt_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          ok_q   <= 1'b0;
          ewdt_q <= 1'b0;
          if (!aligned) begin
            done_q   <= 1'b1;
            ealign_q <= 1'b1;
          end else begin
            ealign_q <= 1'b0;
            page_q   <= addr_i[ADDR_W-1:IDX_W];
            cnt_q    <= '0;
            pass_q   <= '0;
            st_q     <= ST_LOAD;
          end
        end
        ST_LOAD: if (byte_valid_i) begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            st_q  <= ST_XFER;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (byte_last_i) st_q <= ST_PAD;
          end
        end
        ST_PAD, ST_XFER: begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            st_q  <= (st_q == ST_PAD) ? ST_XFER : ST_PULSE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_PULSE: begin
          if (p_trip) begin
            done_q <= 1'b1;
            ewdt_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (p_end) begin
            bad_q <= 1'b0;
            st_q  <= ST_VDUM;
          end
        end
        ST_VDUM: st_q <= ST_VRD;
        ST_VRD:  st_q <= ST_VCAP;
        ST_VCAP: begin
          bad_q <= bad_q | mism;
          if (cnt_q == LAST2) st_q <= ST_EVAL;
          else begin
            cnt_q <= cnt_q + 2'd2;
            st_q  <= cnt_q[1] ? ST_VDUM : ST_VRD;
          end
        end
        ST_EVAL: begin
          if (!bad_q) begin
            done_q <= 1'b1;
            ok_q   <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (pass_q == PC_W'(PASS_MAX - 1)) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            pass_q <= pass_q + 1'b1;
            cnt_q  <= '0;
            st_q   <= ST_XFER;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign byte_ready_o = (st_q == ST_LOAD);
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign pass_o       = ok_q;
  assign err_align_o  = ealign_q;
  assign err_wdt_o    = ewdt_q;
  assign fl_addr_o    = {page_q, ix};
  assign fl_wdata_o   = (st_q == ST_XFER) ? rp_byte : 8'hFF;
  assign fl_latch_o   = (st_q == ST_XFER);
  assign fl_prog_o    = p_act;
  assign fl_dummy_o   = (st_q == ST_VDUM);
  assign fl_read_o    = (st_q == ST_VRD);

  assert_align_reject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i && !aligned) |=> (done_o && err_align_o && !busy_o));
  assert_latch_ascend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_latch_o && $past(fl_latch_o)) |-> fl_addr_o == $past(fl_addr_o) + ADDR_W'(1));
  assert_strobes_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_prog_o |-> !(fl_latch_o || fl_read_o || fl_dummy_o));
  assert_dummy_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_read_o && !fl_addr_o[1]) |-> ($past(fl_dummy_o) && $past(fl_addr_o) == fl_addr_o));
  assert_retry_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_prog_o |-> pass_q < PC_W'(PASS_MAX));
  assert_busy_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(page_q));
  assert_done_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tb_page_prog_seq.sv
`timescale 1ns/1ps
module tb_page_prog_seq;
  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  n;
    logic [3:0]  need;
    logic        ok;
    logic [3:0]  np;
    logic        wd;
    logic        inj;
  } vec_t;

  // wd rows run on the instance with a 6-cycle watchdog
  localparam vec_t VECS [6] = '{
    '{16'h1200, 8'd128, 4'd1, 1'b1, 4'd1, 1'b0, 1'b0},
    '{16'h3480, 8'd5,   4'd1, 1'b1, 4'd1, 1'b0, 1'b0},
    '{16'h0080, 8'd77,  4'd3, 1'b1, 4'd3, 1'b0, 1'b1},
    '{16'h5600, 8'd128, 4'd5, 1'b1, 4'd5, 1'b0, 1'b0},
    '{16'h7780, 8'd40,  4'd6, 1'b0, 4'd5, 1'b0, 1'b0},
    '{16'h2300, 8'd20,  4'd3, 1'b0, 4'd3, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0;
  logic start = 1'b0, bvalid = 1'b0, blast = 1'b0;
  logic [15:0] saddr = '0;
  logic [7:0]  bdata = '0;
  logic [15:0] rdata = '0;

  logic m_rdy, m_busy, m_done, m_pass, m_ea, m_ew, m_lat, m_prg, m_dum, m_rd;
  logic w_rdy, w_busy, w_done, w_pass, w_ea, w_ew, w_lat, w_prg, w_dum, w_rd;
  logic [15:0] m_addr, w_addr;
  logic [7:0]  m_wd, w_wd;

  always #4 clk = ~clk;

  page_prog_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start & ~sel), .addr_i(saddr),
    .byte_valid_i(bvalid & ~sel), .byte_data_i(bdata), .byte_last_i(blast),
    .byte_ready_o(m_rdy), .busy_o(m_busy), .done_o(m_done), .pass_o(m_pass),
    .err_align_o(m_ea), .err_wdt_o(m_ew), .fl_addr_o(m_addr), .fl_wdata_o(m_wd),
    .fl_latch_o(m_lat), .fl_prog_o(m_prg), .fl_dummy_o(m_dum),
    .fl_rdata_i(rdata), .fl_read_o(m_rd));

  page_prog_seq #(.WDT_LIMIT(6)) dut_wd (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start & sel), .addr_i(saddr),
    .byte_valid_i(bvalid & sel), .byte_data_i(bdata), .byte_last_i(blast),
    .byte_ready_o(w_rdy), .busy_o(w_busy), .done_o(w_done), .pass_o(w_pass),
    .err_align_o(w_ea), .err_wdt_o(w_ew), .fl_addr_o(w_addr), .fl_wdata_o(w_wd),
    .fl_latch_o(w_lat), .fl_prog_o(w_prg), .fl_dummy_o(w_dum),
    .fl_rdata_i(rdata), .fl_read_o(w_rd));

  wire        d_rdy  = sel ? w_rdy  : m_rdy;
  wire        d_busy = sel ? w_busy : m_busy;
  wire        d_done = sel ? w_done : m_done;
  wire        d_pass = sel ? w_pass : m_pass;
  wire        d_ea   = sel ? w_ea   : m_ea;
  wire        d_ew   = sel ? w_ew   : m_ew;
  wire        f_lat  = sel ? w_lat  : m_lat;
  wire        f_prg  = sel ? w_prg  : m_prg;
  wire        f_dum  = sel ? w_dum  : m_dum;
  wire        f_rd   = sel ? w_rd   : m_rd;
  wire [15:0] f_addr = sel ? w_addr : m_addr;
  wire [7:0]  f_wd   = sel ? w_wd   : m_wd;

  // array model
  logic [7:0]  mem [256];
  logic [7:0]  lat [128];
  int          pc  [128];
  int          widths [8];
  int          need, npulse, pw, xfer_cnt, proto_err, order_err, overprog;
  logic [15:0] exp_base = '0, dum_addr = '0;
  bit          prev_prog = 1'b0;

  always @(posedge clk) begin
    if (f_lat) begin
      if (f_addr != exp_base + 16'(xfer_cnt % 128)) order_err++;
      lat[f_addr[6:0]] = f_wd;
      xfer_cnt++;
    end
    if (f_dum) begin
      if (f_addr[1:0] != 2'b00 || f_wd != 8'hFF) proto_err++;
      dum_addr = f_addr;
    end
    if (f_rd) begin
      if ({f_addr[15:2], 2'b00} != dum_addr) proto_err++;
      rdata <= {mem[f_addr[7:0] + 8'd1], mem[f_addr[7:0]]};
    end
    if (f_prg) begin
      if (!prev_prog && xfer_cnt != 128 * (npulse + 1)) order_err++;
      pw++;
    end else if (prev_prog) begin
      for (int i = 0; i < 128; i++) begin
        if (lat[i] != 8'hFF) begin
          logic [7:0] ix;
          ix = {exp_base[7], 7'(i)};
          if ((~lat[i] & ~mem[ix]) != 8'h00) overprog++;
          pc[i]++;
          if (!(i % 16 == 3 && pc[i] < need)) mem[ix] = mem[ix] & lat[i];
        end
      end
      if (npulse < 8) widths[npulse] = pw;
      npulse++;
      pw = 0;
    end
    prev_prog = f_prg;
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int v);
    logic [7:0] x;
    x = 8'(i * 29 + v * 53 + 7) ^ 8'(i >> 1);
    if (i % 16 == 3) x[0] = 1'b0;
    return x;
  endfunction

  task automatic clr_model();
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    for (int i = 0; i < 128; i++) begin lat[i] = 8'hFF; pc[i] = 0; end
    for (int i = 0; i < 8; i++) widths[i] = 0;
    npulse = 0; pw = 0; xfer_cnt = 0; proto_err = 0; order_err = 0; overprog = 0;
  endtask

  task automatic wait_done(output bit seen);
    int t;
    t = 0;
    while (!d_done && t < 20000) begin @(negedge clk); t++; end
    seen = d_done;
  endtask

  task automatic run_vec(input vec_t vc, input int v);
    bit seen;
    int n, mm, ew;
    n = int'(vc.n);
    clr_model();
    need = int'(vc.need);
    exp_base = vc.addr;
    sel = vc.wd;
    @(negedge clk);
    start = 1'b1; saddr = vc.addr;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      bvalid = 1'b1; bdata = pat(i, v); blast = (n < 128 && i == n - 1);
      while (!d_rdy) @(negedge clk);
      @(negedge clk);
    end
    blast = 1'b0;
    if (n == 128) begin
      chk(!d_rdy, "R2 ready drops after 128 bytes", int'(d_rdy), 0);
    end
    bvalid = 1'b0;
    if (vc.inj) begin
      @(negedge clk);
      start = 1'b1; saddr = 16'h4400;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(seen);
    chk(seen, vc.ok ? "R8 done seen" : "R9 done seen", int'(seen), 1);
    chk(d_pass == vc.ok, vc.ok ? "R8 pass flag" : "R9 pass flag", int'(d_pass), int'(vc.ok));
    chk(d_ew == vc.wd, "R10 watchdog flag", int'(d_ew), int'(vc.wd));
    chk(!d_ea, "R1 no align error", int'(d_ea), 0);
    chk(npulse == int'(vc.np), "R9 pulse count", npulse, int'(vc.np));
    for (int k = 0; k < npulse && k < 8; k++) begin
      ew = (k < 2) ? 4 : (vc.wd ? 6 : 9);
      chk(widths[k] == ew, vc.wd && k >= 2 ? "R10 cut pulse width" : "R5 pulse width",
          widths[k], ew);
    end
    chk(order_err == 0, "R4 latch order", order_err, 0);
    chk(proto_err == 0, "R6 verify protocol", proto_err, 0);
    chk(overprog == 0, "R7 no double program", overprog, 0);
    if (vc.ok) begin
      mm = 0;
      for (int i = 0; i < 128; i++)
        if (mem[{vc.addr[7], 7'(i)}] != ((i < n) ? pat(i, v) : 8'hFF)) mm++;
      chk(mm == 0, "R3 page content with padding", mm, 0);
    end
    if (vc.inj) begin
      mm = 0;
      for (int i = 0; i < 128; i++) if (mem[i] != 8'hFF) mm++;
      chk(mm == 0, "R11 other page untouched", mm, 0);
    end
    @(negedge clk);
    chk(!d_done, "R12 done one cycle", int'(d_done), 0);
    chk(d_pass == vc.ok, "R12 status held", int'(d_pass), int'(vc.ok));
    if (vc.inj) begin
      mm = 0;
      for (int t = 0; t < 50; t++) begin @(negedge clk); if (d_done || d_busy) mm++; end
      chk(mm == 0, "R11 busy start ignored", mm, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clr_model();
    need = 1;
    repeat (3) @(negedge clk);
    chk(!m_busy && !m_done && !m_rdy && !m_prg && !m_lat && !m_pass,
        "R12 reset state", int'({m_busy, m_done, m_rdy, m_prg, m_lat, m_pass}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_busy && !m_done && !m_ea && !m_ew && !m_dum && !m_rd,
        "R12 idle after reset", int'({m_busy, m_done, m_ea, m_ew, m_dum, m_rd}), 0);

    for (int v = 0; v < 6; v++) run_vec(VECS[v], v);

    // alignment rejects
    sel = 1'b0;
    clr_model();
    foreach (VECS[j]) begin end
    for (int a = 0; a < 2; a++) begin
      @(negedge clk);
      start = 1'b1; saddr = (a == 0) ? 16'h1240 : 16'h12FF;
      @(negedge clk);
      start = 1'b0;
      chk(m_done && m_ea && !m_pass, "R1 align reject strobe",
          int'({m_done, m_ea, m_pass}), 6);
      @(negedge clk);
      chk(!m_done && !m_busy && m_ea, "R1 no sequence after reject",
          int'({m_done, m_busy, m_ea}), 1);
      repeat (20) @(negedge clk);
      chk(xfer_cnt == 0 && npulse == 0, "R1 array untouched", xfer_cnt + npulse, 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule